// File: doc/BRIEF.md
# Two-wire bus status flag unit

This block holds the event flags of a two-wire (I2C-style) bus controller, together with the transfer byte counter that decides when a transfer or a reload segment has finished. The bus protocol engine feeds it single-cycle event pulses: byte done, stop seen, NACK received, own address matched, arbitration lost, misplaced start/stop, and overrun/underrun. Software acts on it through a write-one-to-clear vector, writes to the byte-count field, and start/stop request strobes. The block also takes the mode configuration bits.

Each flag has its own set condition and its own clear path. The two completion flags depend on the reload and auto-end modes. Software clears them by writing the byte count or by requesting a start or a stop. Their clear-vector bits do nothing. When an event and a clear reach the same flag in the same cycle, the event wins. A masked OR of the flags drives a registered interrupt.

Flag vector bit positions, used by the clear vector and the interrupt enables: 0 address match, 1 NACK, 2 stop, 3 transfer complete, 4 reload complete, 5 bus error, 6 arbitration lost, 7 overrun/underrun.

Top module: `twi_status_flags`

## Requirements
- R1: While `en_i` is low or `swrst_i` is high at a clock edge, every flag in `flags_o` is 0 after that edge. The addressed tracker and the byte counter also return to 0. Events that arrive in that cycle are ignored.
- R2: Flag bit 7 (overrun/underrun) sets on `ev_ovr_i` only when `cfg_master_i`=0 and `cfg_nostretch_i`=1. A 1 in clear bit 7 clears it.
- R3: Flag bit 6 sets on `ev_arlo_i` and flag bit 5 sets on `ev_berr_i`. Clear bits 6 and 5 clear them.
- R4: Flag bit 4 (reload complete) sets when `cfg_reload_i`=1 and the last byte of the loaded count is done. A count write with a non-zero value clears it. A count write of zero leaves it unchanged.
- R5: Flag bit 4 can set only when `cfg_master_i`=1, or when `cfg_master_i`=0 and `cfg_sbc_i`=1.
- R6: Flag bit 3 (transfer complete) sets when the count is reached with `cfg_master_i`=1, `cfg_reload_i`=0 and `cfg_autoend_i`=0. `start_req_i` or `stop_req_i` clears it. Clear bit 3 has no effect.
- R7: Flag bit 2 sets on `ev_stop_i` in two cases. As master, `ev_stop_self_i` must also be high. As slave, an address match must have occurred since the last stop flag was set. Clear bit 2 clears it.
- R8: Flag bit 1 sets on `ev_nack_i` and flag bit 0 sets on `ev_addr_i`. Clear bits 1 and 0 clear them.
- R9: An event and a software clear on the same flag in the same cycle leave the flag set.
- R10: The byte counter loads in two cases. On `start_req_i` it loads the last written count, or the value written in the same cycle. On a non-zero count write it loads that value. Each `ev_byte_done_i` decrements it, and the byte that takes it from 1 to 0 completes the transfer. A load has priority over a decrement.
- R11: `irq_o` is high one cycle after any flag whose `irq_en_i` bit is 1 is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Peripheral enable |
| swrst_i | input | 1 | Software reset |
| cfg_reload_i | input | 1 | Reload mode |
| cfg_autoend_i | input | 1 | Automatic stop after count |
| cfg_nostretch_i | input | 1 | Clock stretching disabled |
| cfg_master_i | input | 1 | 1 master, 0 slave |
| cfg_sbc_i | input | 1 | Slave byte control enable |
| ev_byte_done_i | input | 1 | Byte transferred pulse |
| ev_stop_i | input | 1 | Stop condition seen |
| ev_stop_self_i | input | 1 | Stop was generated by this block |
| ev_nack_i | input | 1 | NACK after transmitted byte |
| ev_addr_i | input | 1 | Own address matched |
| ev_arlo_i | input | 1 | Arbitration lost |
| ev_berr_i | input | 1 | Misplaced start/stop |
| ev_ovr_i | input | 1 | Overrun/underrun |
| clr_we_i | input | 1 | Clear vector write strobe |
| clr_i | input | 8 | Write-one-to-clear vector |
| cnt_we_i | input | 1 | Byte-count field write strobe |
| cnt_i | input | 8 | Byte-count value |
| start_req_i | input | 1 | Start request |
| stop_req_i | input | 1 | Stop request |
| irq_en_i | input | 8 | Per-flag interrupt enable |
| flags_o | output | 8 | Flag vector |
| irq_o | output | 1 | Registered interrupt |

## Verification
The stop flag in slave mode is the hardest case to reach. It depends on a hidden tracker that only an address match arms and that the stop flag itself disarms. The stimulus first sends a stop with no prior match, then a match followed by a stop, then a second stop with no new match, so that the tracker's arm and disarm are both seen at the flag. The reload-complete flag is also hard to reach, because its set needs a counter that was loaded earlier. Each reload case therefore writes a count, walks the byte pulses down to zero, and only then tries the zero and non-zero clear writes.

// File: rtl/twi_flag_pkg.sv
package twi_flag_pkg;
  localparam int unsigned NFLAG = 8;
  localparam int unsigned F_ADDR = 0;
  localparam int unsigned F_NACK = 1;
  localparam int unsigned F_STOP = 2;
  localparam int unsigned F_TC   = 3;
  localparam int unsigned F_TCR  = 4;
  localparam int unsigned F_BERR = 5;
  localparam int unsigned F_ARLO = 6;
  localparam int unsigned F_OVR  = 7;
endpackage

// File: rtl/twi_byte_counter.sv
module twi_byte_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             start_req_i,
  input  logic             byte_done_i,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] nbytes_q, cnt_q, load_val;
  logic             load;

  assign load     = start_req_i || (cnt_we_i && cnt_i != '0);
  assign load_val = cnt_we_i ? cnt_i : nbytes_q;
  assign done_o   = active_i && byte_done_i && !load && cnt_q == ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nbytes_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (cnt_we_i) nbytes_q <= cnt_i;
      if (!active_i)                      cnt_q <= '0;
      else if (load)                      cnt_q <= load_val;
      else if (byte_done_i && cnt_q != 0) cnt_q <= cnt_q - ONE;
    end
  end

  // R10
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && start_req_i && !cnt_we_i) |=> cnt_q == $past(nbytes_q));
  // R10
  dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && byte_done_i && !load && cnt_q != 0) |=> cnt_q == $past(cnt_q) - ONE);
endmodule

// File: rtl/twi_flag_bank.sv
module twi_flag_bank
  import twi_flag_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             cfg_reload_i,
  input  logic             cfg_autoend_i,
  input  logic             cfg_nostretch_i,
  input  logic             cfg_master_i,
  input  logic             cfg_sbc_i,
  input  logic             done_i,
  input  logic             ev_stop_i,
  input  logic             ev_stop_self_i,
  input  logic             ev_nack_i,
  input  logic             ev_addr_i,
  input  logic             ev_arlo_i,
  input  logic             ev_berr_i,
  input  logic             ev_ovr_i,
  input  logic             clr_we_i,
  input  logic [NFLAG-1:0] clr_i,
  input  logic             tcr_clr_i,
  input  logic             tc_clr_i,
  output logic [NFLAG-1:0] flags_o
);
  logic [NFLAG-1:0] set_v, clr_v, flag_q;
  logic             addressed_q;

  always_comb begin
    set_v         = '0;
    set_v[F_ADDR] = ev_addr_i;
    set_v[F_NACK] = ev_nack_i;
    set_v[F_STOP] = ev_stop_i && (cfg_master_i ? ev_stop_self_i : addressed_q);
    set_v[F_TC]   = done_i && cfg_master_i && !cfg_reload_i && !cfg_autoend_i;
    set_v[F_TCR]  = done_i && cfg_reload_i && (cfg_master_i || cfg_sbc_i);
    set_v[F_BERR] = ev_berr_i;
    set_v[F_ARLO] = ev_arlo_i;
    set_v[F_OVR]  = ev_ovr_i && !cfg_master_i && cfg_nostretch_i;
  end

  always_comb begin
    clr_v        = clr_we_i ? clr_i : '0;
    clr_v[F_TC]  = tc_clr_i;
    clr_v[F_TCR] = tcr_clr_i;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[i] <= 1'b0;
      else if (!active_i) flag_q[i] <= 1'b0;
      else if (set_v[i])  flag_q[i] <= 1'b1;  // set beats clear
      else if (clr_v[i])  flag_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                addressed_q <= 1'b0;
    else if (!active_i)         addressed_q <= 1'b0;
    else if (set_v[F_STOP])     addressed_q <= 1'b0;
    else if (ev_addr_i)         addressed_q <= 1'b1;
  end

  assign flags_o = flag_q;

  // R1
  off_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> flags_o == '0);
  // R2
  ovr_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[F_OVR]) |-> $past(!cfg_master_i && cfg_nostretch_i && ev_ovr_i));
  // R6
  tc_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[F_TC]) |-> $past(cfg_master_i && !cfg_reload_i && !cfg_autoend_i));
  // R5
  tcr_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[F_TCR]) |-> $past(cfg_master_i || cfg_sbc_i));
  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && ev_arlo_i) |=> flags_o[F_ARLO]);
endmodule

// File: rtl/twi_irq_gen.sv
module twi_irq_gen #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] irq_en_i,
  output logic         irq_o
);
  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(flags_i & irq_en_i);
  end
  assign irq_o = irq_q;

  // R11
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(flags_i != '0));
endmodule

// File: rtl/twi_status_flags.sv
module twi_status_flags
  import twi_flag_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             swrst_i,
  input  logic             cfg_reload_i,
  input  logic             cfg_autoend_i,
  input  logic             cfg_nostretch_i,
  input  logic             cfg_master_i,
  input  logic             cfg_sbc_i,
  input  logic             ev_byte_done_i,
  input  logic             ev_stop_i,
  input  logic             ev_stop_self_i,
  input  logic             ev_nack_i,
  input  logic             ev_addr_i,
  input  logic             ev_arlo_i,
  input  logic             ev_berr_i,
  input  logic             ev_ovr_i,
  input  logic             clr_we_i,
  input  logic [NFLAG-1:0] clr_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             start_req_i,
  input  logic             stop_req_i,
  input  logic [NFLAG-1:0] irq_en_i,
  output logic [NFLAG-1:0] flags_o,
  output logic             irq_o
);
  logic active, done;
  assign active = en_i && !swrst_i;

  twi_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .active_i(active), .cnt_we_i, .cnt_i,
    .start_req_i, .byte_done_i(ev_byte_done_i), .done_o(done)
  );

  twi_flag_bank u_bank (
    .clk_i, .rst_ni, .active_i(active),
    .cfg_reload_i, .cfg_autoend_i, .cfg_nostretch_i, .cfg_master_i, .cfg_sbc_i,
    .done_i(done), .ev_stop_i, .ev_stop_self_i, .ev_nack_i, .ev_addr_i,
    .ev_arlo_i, .ev_berr_i, .ev_ovr_i, .clr_we_i, .clr_i,
    .tcr_clr_i(cnt_we_i && cnt_i != '0),
    .tc_clr_i(start_req_i || stop_req_i),
    .flags_o
  );

  twi_irq_gen #(.N(NFLAG)) u_irq (
    .clk_i, .rst_ni, .flags_i(flags_o), .irq_en_i, .irq_o
  );
endmodule

// File: tb/sim_twi_status_flags.sv
module sim_twi_status_flags;
  logic clk = 0, rst_ni = 0;
  logic en = 0, swrst = 0, reload = 0, autoend = 0, nostretch = 0, master = 0, sbc = 0;
  logic bd = 0, stp = 0, stp_self = 0, nack = 0, addr = 0, arlo = 0, berr = 0, ovr = 0;
  logic clr_we = 0, cnt_we = 0, sreq = 0, preq = 0;
  logic [7:0] clr = 0, cnt = 0, ien = 0;
  logic [7:0] flags;
  logic irq;

  int checks = 0, fails = 0;
  bit [7:0] m_flags = 0;
  bit m_irq = 0, m_addressed = 0;
  int m_cnt = 0, m_nb = 0;

  always #5 clk = ~clk;

  twi_status_flags u0 (
    .clk_i(clk), .rst_ni, .en_i(en), .swrst_i(swrst),
    .cfg_reload_i(reload), .cfg_autoend_i(autoend), .cfg_nostretch_i(nostretch),
    .cfg_master_i(master), .cfg_sbc_i(sbc),
    .ev_byte_done_i(bd), .ev_stop_i(stp), .ev_stop_self_i(stp_self), .ev_nack_i(nack),
    .ev_addr_i(addr), .ev_arlo_i(arlo), .ev_berr_i(berr), .ev_ovr_i(ovr),
    .clr_we_i(clr_we), .clr_i(clr), .cnt_we_i(cnt_we), .cnt_i(cnt),
    .start_req_i(sreq), .stop_req_i(preq), .irq_en_i(ien),
    .flags_o(flags), .irq_o(irq)
  );

  task automatic model_edge();
    bit on, ld, fin, stop_hit;
    bit [7:0] nxt;
    on = en && !swrst;
    m_irq = (m_flags & ien) != 0;
    ld = sreq || (cnt_we && cnt != 0);
    fin = on && bd && !ld && m_cnt == 1;
    if (!on) begin
      m_flags = 0; m_cnt = 0; m_addressed = 0;
    end else begin
      nxt = m_flags;
      if (clr_we) begin
        for (int i = 0; i < 8; i++)
          if (clr[i] && i != 3 && i != 4) nxt[i] = 0;
      end
      if (sreq || preq) nxt[3] = 0;
      if (cnt_we && cnt != 0) nxt[4] = 0;
      stop_hit = stp && (master ? stp_self : m_addressed);
      if (addr) nxt[0] = 1;
      if (nack) nxt[1] = 1;
      if (stop_hit) nxt[2] = 1;
      if (fin && master && !reload && !autoend) nxt[3] = 1;
      if (fin && reload && (master || sbc)) nxt[4] = 1;
      if (berr) nxt[5] = 1;
      if (arlo) nxt[6] = 1;
      if (ovr && !master && nostretch) nxt[7] = 1;
      m_flags = nxt;
      if (stop_hit) m_addressed = 0;
      else if (addr) m_addressed = 1;
      if (ld) m_cnt = cnt_we ? int'(cnt) : m_nb;
      else if (bd && m_cnt > 0) m_cnt--;
    end
    if (cnt_we) m_nb = int'(cnt);
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    checks++;
    if (flags !== m_flags) begin
      fails++;
      $display("FAIL %s flags actual=%b expected=%b", tag, flags, m_flags);
    end
    checks++;
    if (irq !== m_irq) begin
      fails++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, m_irq);
    end
    bd = 0; stp = 0; stp_self = 0; nack = 0; addr = 0; arlo = 0; berr = 0; ovr = 0;
    clr_we = 0; clr = 0; cnt_we = 0; cnt = 0; sreq = 0; preq = 0;
  endtask

  task automatic want(input string tag, input int idx, input bit exp);
    checks++;
    if (flags[idx] !== exp) begin
      fails++;
      $display("FAIL %s bit%0d actual=%b expected=%b", tag, idx, flags[idx], exp);
    end
  endtask

  task automatic wclr(input int idx);
    clr_we = 1; clr = 8'(1) << idx;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_ni = 1;
    tick("R1");
    checks++;
    if (flags !== 8'h00 || irq !== 1'b0) begin
      fails++; $display("FAIL R1 reset actual=%b expected=00000000", flags);
    end
    en = 1; master = 1;
    // R10 / R6 count of 3
    cnt_we = 1; cnt = 3; tick("R10");
    sreq = 1; tick("R10");
    bd = 1; tick("R10"); bd = 1; tick("R10"); want("R10", 3, 0);
    bd = 1; tick("R6"); want("R6", 3, 1);
    ien = 8'h08; tick("R11");
    checks++;
    if (irq !== 1'b1) begin fails++; $display("FAIL R11 irq actual=%b expected=1", irq); end
    wclr(3); tick("R6"); want("R6", 3, 1);
    preq = 1; tick("R6"); want("R6", 3, 0);
    tick("R11"); ien = 0;
    // autoend suppresses completion
    autoend = 1; sreq = 1; tick("R10");
    repeat (3) begin bd = 1; tick("R10"); end
    want("R10", 3, 0); autoend = 0;
    // reload complete
    reload = 1; cnt_we = 1; cnt = 2; tick("R4");
    bd = 1; tick("R4"); bd = 1; tick("R4"); want("R4", 4, 1); want("R4", 3, 0);
    cnt_we = 1; cnt = 0; tick("R4"); want("R4", 4, 1);
    wclr(4); tick("R4"); want("R4", 4, 1);
    cnt_we = 1; cnt = 2; tick("R4"); want("R4", 4, 0);
    // slave reload: needs slave byte control
    master = 0; sbc = 0; cnt_we = 1; cnt = 1; tick("R5");
    bd = 1; tick("R5"); want("R5", 4, 0);
    sbc = 1; cnt_we = 1; cnt = 1; tick("R5");
    bd = 1; tick("R5"); want("R5", 4, 1);
    cnt_we = 1; cnt = 5; tick("R4"); want("R4", 4, 0);
    reload = 0; sbc = 0;
    cnt_we = 1; cnt = 1; tick("R6"); bd = 1; tick("R6"); want("R6", 3, 0);
    // overrun
    nostretch = 1; ovr = 1; tick("R2"); want("R2", 7, 1);
    wclr(7); tick("R2"); want("R2", 7, 0);
    nostretch = 0; ovr = 1; tick("R2"); want("R2", 7, 0);
    master = 1; nostretch = 1; ovr = 1; tick("R2"); want("R2", 7, 0);
    nostretch = 0;
    // arbitration / bus error
    arlo = 1; berr = 1; tick("R3"); want("R3", 6, 1); want("R3", 5, 1);
    wclr(6); tick("R3"); want("R3", 6, 0); want("R3", 5, 1);
    wclr(5); tick("R3"); want("R3", 5, 0);
    // stop participation
    stp = 1; stp_self = 1; tick("R7"); want("R7", 2, 1);
    wclr(2); tick("R7"); want("R7", 2, 0);
    stp = 1; tick("R7"); want("R7", 2, 0);
    master = 0; stp = 1; tick("R7"); want("R7", 2, 0);
    addr = 1; tick("R8"); want("R8", 0, 1);
    wclr(0); tick("R8"); want("R8", 0, 0);
    stp = 1; tick("R7"); want("R7", 2, 1);
    wclr(2); tick("R7");
    stp = 1; tick("R7"); want("R7", 2, 0);
    // nack
    nack = 1; tick("R8"); want("R8", 1, 1);
    wclr(1); tick("R8"); want("R8", 1, 0);
    // set beats clear
    nack = 1; wclr(1); tick("R9"); want("R9", 1, 1);
    arlo = 1; clr_we = 1; clr = 8'hff; tick("R9"); want("R9", 6, 1); want("R9", 1, 0);
    // disable and software reset
    berr = 1; addr = 1; tick("R1");
    en = 0; arlo = 1; tick("R1");
    checks++;
    if (flags !== 8'h00) begin fails++; $display("FAIL R1 disable actual=%b expected=00000000", flags); end
    en = 1; tick("R1");
    addr = 1; nack = 1; tick("R1");
    swrst = 1; nack = 1; tick("R1");
    checks++;
    if (flags !== 8'h00) begin fails++; $display("FAIL R1 swrst actual=%b expected=00000000", flags); end
    swrst = 0; stp = 1; tick("R1"); want("R1", 2, 0);
    tick("R1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule